// File: doc/BRIEF.md
# Two-Wire Bus Clock-Stuck and Idle Watchdog

This block sits beside a two-wire serial bus interface and watches the clock and data lines. It raises a timeout flag when the clock line is held low for too long. At the same moment it issues a reset request of fixed length to the protocol logic, so that a stuck transfer is abandoned well before the allowed recovery window closes.

The block also keeps a bus-free flag for a local master that wants to start a transfer. The flag is set when a STOP condition is seen, or when both lines have stayed high long enough while the idle check is enabled. It is cleared by a START condition.

All time limits are given in microseconds and converted to counts of a prescaled tick input. Both lines are synchronized inside the block before any edge or level is detected.

Top module: `bus_watch`

## Requirements
- R1: After reset, `timeout_o`, `rst_req_o` and `free_o` are all 0.
- R2: When `scl_i` falls, `timeout_o` rises at the (LOW_TICKS+2)-th rising clock edge after the change, with LOW_TICKS = LOW_LIMIT_US/TICK_US and `tick_i` held at 1. Two of those edges are synchronizer latency.
- R3: Each return of the synchronized clock line to high reloads the low-period counter. A low period shorter than the limit causes no timeout, and a new low period is timed again in full.
- R4: `timeout_o` clears on the third rising edge after `scl_i` returns high. While the clock line stays low, only one reset request is issued.
- R5: `rst_req_o` rises in the same cycle as `timeout_o` and stays high for exactly RST_CYCLES clock cycles.
- R6: With `free_en_i` = 1, once both lines are high, `free_o` rises after FREE_TICKS ticks, with FREE_TICKS = FREE_LIMIT_US/TICK_US.
- R7: The idle count restarts whenever either synchronized line is low. An idle period that is broken before it reaches the limit does not set `free_o`.
- R8: With `free_en_i` = 0, idle time never sets `free_o`.
- R9: A STOP (data rises while clock is high) sets `free_o` on the third rising edge after the change, whatever the value of `free_en_i`.
- R10: A START (data falls while clock is high) clears `free_o` on the third rising edge after the change.
- R11: Both counters advance only in cycles where `tick_i` = 1. With no ticks, a low clock line never produces a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaled time base, one cycle per TICK_US |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| free_en_i | input | 1 | Enables bus-free detection by idle time |
| timeout_o | output | 1 | Clock line held low past the limit |
| rst_req_o | output | 1 | Reset request pulse to the protocol logic |
| free_o | output | 1 | Bus considered free |

## Verification
The hardest case to reach from the ports is an idle period that is almost complete and is then cut short. Here the counter must be one or two ticks from expiry when a line drops, and the lines must not form a STOP while doing so. The bench first lowers the clock line and then raises data while the clock is low, so no STOP is formed. It then raises the clock and pulls it low again a counted number of edges later, with the two synchronizer stages included in the count. The expected expiry edge then passes with no flag, and a fresh full count follows.

// File: rtl/bw_pkg.sv
package bw_pkg;

  typedef struct packed {
    logic scl;
    logic sda;
  } bw_line_t;

  // Converts a time limit into a tick count, never less than one tick.
  function automatic int ticks_of(input int limit_us, input int tick_us);
    int n;
    n = limit_us / tick_us;
    return (n < 1) ? 1 : n;
  endfunction

endpackage

// File: rtl/bw_sync.sv
module bw_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/bw_low_timer.sv
module bw_low_timer #(
  parameter int CNT_W      = 16,
  parameter int LOW_TICKS  = 2500,
  parameter int RST_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic scl_s,
  output logic timeout_o,
  output logic rst_req_o
);

  localparam int unsigned RELOAD_I = (1 << CNT_W) - LOW_TICKS;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(RELOAD_I);
  localparam int PW = $clog2(RST_CYCLES + 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(RST_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    pulse_q;
  logic             fire;

  // Overflow of the up-counter while the clock line is still low.
  assign fire = !scl_s && tick_i && !timeout_o && (cnt_q == '1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q     <= RELOAD;
      timeout_o <= 1'b0;
    end else if (scl_s) begin
      cnt_q     <= RELOAD;
      timeout_o <= 1'b0;
    end else if (fire) begin
      cnt_q     <= RELOAD;
      timeout_o <= 1'b1;
    end else if (tick_i && !timeout_o) begin
      cnt_q     <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rst_req_o <= 1'b0;
      pulse_q   <= '0;
    end else if (fire) begin
      rst_req_o <= 1'b1;
      pulse_q   <= PULSE_LAST;
    end else if (rst_req_o) begin
      if (pulse_q == '0) rst_req_o <= 1'b0;
      else               pulse_q   <= pulse_q - 1'b1;
    end
  end

endmodule

// File: rtl/bw_idle_timer.sv
module bw_idle_timer #(
  parameter int FREE_TICKS = 5
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic en_i,
  input  logic scl_s,
  input  logic sda_s,
  output logic free_o
);

  localparam int IW = $clog2(FREE_TICKS + 1);
  localparam logic [IW-1:0] LAST = IW'(FREE_TICKS - 1);

  logic [IW-1:0] cnt_q;
  logic          sda_q;
  logic          both_hi, start_c, stop_c, expire;

  assign both_hi = scl_s && sda_s;
  assign start_c = scl_s && sda_q && !sda_s;
  assign stop_c  = scl_s && !sda_q && sda_s;
  assign expire  = en_i && both_hi && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sda_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      sda_q <= sda_s;
      if (!both_hi || !en_i)             cnt_q <= '0;
      else if (tick_i && cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)                 free_o <= 1'b0;
    else if (start_c)          free_o <= 1'b0;
    else if (stop_c || expire) free_o <= 1'b1;
  end

endmodule

// File: rtl/bus_watch.sv
module bus_watch #(
  parameter int TICK_US       = 10,
  parameter int LOW_LIMIT_US  = 25000,
  parameter int FREE_LIMIT_US = 50,
  parameter int RST_CYCLES    = 16,
  parameter int CNT_W         = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic free_en_i,
  output logic timeout_o,
  output logic rst_req_o,
  output logic free_o
);

  import bw_pkg::*;

  localparam int LOW_TICKS  = ticks_of(LOW_LIMIT_US, TICK_US);
  localparam int FREE_TICKS = ticks_of(FREE_LIMIT_US, TICK_US);

  bw_line_t raw_lines, sync_lines;
  logic     scl_s, sda_s;

  assign raw_lines = '{scl: scl_i, sda: sda_i};

  bw_sync #(.W($bits(bw_line_t)), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (raw_lines),
    .q_o   (sync_lines)
  );

  assign scl_s = sync_lines.scl;
  assign sda_s = sync_lines.sda;

  bw_low_timer #(
    .CNT_W      (CNT_W),
    .LOW_TICKS  (LOW_TICKS),
    .RST_CYCLES (RST_CYCLES)
  ) u_low (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .tick_i    (tick_i),
    .scl_s     (scl_s),
    .timeout_o (timeout_o),
    .rst_req_o (rst_req_o)
  );

  bw_idle_timer #(.FREE_TICKS(FREE_TICKS)) u_idle (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .tick_i (tick_i),
    .en_i   (free_en_i),
    .scl_s  (scl_s),
    .sda_s  (sda_s),
    .free_o (free_o)
  );

endmodule

// File: rtl/bus_watch_chk.sv
module bus_watch_chk #(
  parameter int RST_CYCLES = 16
) (
  input logic clk_i,
  input logic rst_i,
  input logic scl_s,
  input logic sda_s,
  input logic free_en_i,
  input logic timeout_o,
  input logic rst_req_o,
  input logic free_o
);

  int unsigned req_len;

  always_ff @(posedge clk_i) begin
    if (rst_i || !rst_req_o) req_len <= 0;
    else                     req_len <= req_len + 1;
  end

  // R5: request starts together with the flag
  assert_req_with_flag_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(rst_req_o) |-> $rose(timeout_o));

  // R5: pulse never longer than the configured length
  assert_req_bounded_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    rst_req_o |-> (req_len < RST_CYCLES));

  // R5: pulse ends exactly at its configured length
  assert_req_length_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_req_o) |-> (req_len == RST_CYCLES));

  // R4: a high clock line clears the flag
  assert_flag_clears_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (timeout_o && scl_s) |=> !timeout_o);

  // R10: START drops the free flag
  assert_start_busy_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (scl_s && $fell(sda_s)) |=> !free_o);

  // R9: STOP raises the free flag
  assert_stop_free_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (scl_s && $rose(sda_s)) |=> free_o);

  // R8: without enable only a STOP can free the bus
  assert_noen_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!free_en_i && !free_o && !(scl_s && $rose(sda_s))) |=> !free_o);

endmodule

bind bus_watch bus_watch_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (.*);

// File: tb/bus_watch_tb.sv
`timescale 1ns/1ps
module bus_watch_tb;

  localparam int LOW  = 40;
  localparam int FREE = 6;
  localparam int RSTN = 4;

  logic clk = 1'b0;
  logic rst, tick, scl, sda, en;
  logic timeout, rst_req, free;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_watch #(
    .TICK_US(1), .LOW_LIMIT_US(LOW), .FREE_LIMIT_US(FREE),
    .RST_CYCLES(RSTN), .CNT_W(16), .SYNC_STAGES(2)
  ) u_dut (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .scl_i(scl), .sda_i(sda),
    .free_en_i(en), .timeout_o(timeout), .rst_req_o(rst_req), .free_o(free)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; tick = 1'b1; scl = 1'b1; sda = 1'b1; en = 1'b0;
    step(3);
    rst = 1'b0;
    step(1);
    chk(timeout, 1'b0, "R1 timeout after reset");
    chk(rst_req, 1'b0, "R1 rst_req after reset");
    chk(free,    1'b0, "R1 free after reset");
  endtask

  task automatic t_timeout;
    int n;
    scl = 1'b0;
    step(LOW + 1);
    chk(timeout, 1'b0, "R2 no timeout one edge early");
    step(1);
    chk(timeout, 1'b1, "R2 timeout at limit");
    chk(rst_req, 1'b1, "R5 request with flag");
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (rst_req) n++;
      step(1);
    end
    chk(n == RSTN, 1'b1, "R5 pulse length");
    n = 0;
    for (int i = 0; i < 2 * LOW; i++) begin
      if (rst_req) n++;
      step(1);
    end
    chk(n == 0, 1'b1, "R4 single request per low period");
    chk(timeout, 1'b1, "R4 flag held while low");
    scl = 1'b1;
    step(2);
    chk(timeout, 1'b1, "R4 flag before clear edge");
    step(1);
    chk(timeout, 1'b0, "R4 flag cleared by high clock");
  endtask

  task automatic t_restart;
    int n;
    scl = 1'b0;
    step(LOW - 2);
    scl = 1'b1;
    n = 0;
    for (int i = 0; i < 4; i++) begin
      if (timeout) n++;
      step(1);
    end
    chk(n == 0, 1'b1, "R3 short low gives no timeout");
    scl = 1'b0;
    step(LOW + 1);
    chk(timeout, 1'b0, "R3 reloaded count not early");
    step(1);
    chk(timeout, 1'b1, "R3 full count after reload");
    scl = 1'b1;
    step(4);
  endtask

  task automatic t_tick;
    tick = 1'b0;
    scl = 1'b0;
    step(3 * LOW);
    chk(timeout, 1'b0, "R11 no count without ticks");
    tick = 1'b1;
    step(LOW - 1);
    chk(timeout, 1'b0, "R11 count resumes one tick early");
    step(1);
    chk(timeout, 1'b1, "R11 count resumes to limit");
    scl = 1'b1;
    step(RSTN + 4);
  endtask

  task automatic t_noen;
    en = 1'b0;
    step(4 * FREE);
    chk(free, 1'b0, "R8 idle ignored when disabled");
  endtask

  task automatic t_idle;
    en = 1'b1;
    step(FREE - 1);
    chk(free, 1'b0, "R6 free one tick early");
    step(1);
    chk(free, 1'b1, "R6 free after idle limit");
  endtask

  task automatic t_start;
    sda = 1'b0;
    step(2);
    chk(free, 1'b1, "R10 free before start seen");
    step(1);
    chk(free, 1'b0, "R10 start clears free");
  endtask

  task automatic t_idle_clear;
    int n;
    scl = 1'b0;
    step(4);
    sda = 1'b1;
    step(4);
    chk(free, 1'b0, "R7 data rise with clock low is no stop");
    scl = 1'b1;
    step(FREE - 3);
    scl = 1'b0;
    n = 0;
    for (int i = 0; i < 6; i++) begin
      if (free) n++;
      step(1);
    end
    chk(n == 0, 1'b1, "R7 broken idle does not free");
    scl = 1'b1;
    step(FREE + 1);
    chk(free, 1'b0, "R7 idle count restarted");
    step(1);
    chk(free, 1'b1, "R7 full idle after restart");
  endtask

  task automatic t_stop;
    en = 1'b0;
    sda = 1'b0;
    step(4);
    chk(free, 1'b0, "R9 start before stop");
    sda = 1'b1;
    step(2);
    chk(free, 1'b0, "R9 free before stop seen");
    step(1);
    chk(free, 1'b1, "R9 stop frees bus with enable off");
  endtask

  initial begin
    t_reset();
    t_timeout();
    t_restart();
    t_tick();
    t_noen();
    t_idle();
    t_start();
    t_idle_clear();
    t_stop();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule